// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block produces the serial clock for an I2C master. It counts reference clock cycles for each part of the SCL waveform. The phases are the START hold interval, the low phase and the high phase. Each phase length is a programmed count plus a fixed overhead. Two count pairs are held, one for standard speed and one for fast speed, and a speed-select input chooses which pair is used. The count and speed inputs are captured only while the block is disabled, so a transfer in flight always runs on one consistent set of values. A count below a fixed floor is raised to that floor before it is used.

The SCL output is open-drain. The block asserts `scl_drive_low` for the whole low phase and releases the line at all other times. The low phase is counted from the cycle in which the block starts pulling SCL low, so the SCL fall time is part of the programmed low time. A bus sequencer drives the block with three requests. `start_req` begins a START hold. `run_req` asks for another clock period once the current high phase ends. `stop_req` ends the transfer after the current high phase. One-cycle strobes mark each SCL falling edge and each rising edge, and the sequencer uses them to place data changes.

Top module: `scl_timing_gen`

## Requirements
- R1: When `speed_fast` is 1, the fast count pair (`fast_hi_cnt`, `fast_lo_cnt`) sets all phase lengths. When it is 0, the standard pair (`std_hi_cnt`, `std_lo_cnt`) sets them.
- R2: A low phase keeps `scl_drive_low` at 1 for exactly max(L,8)+1 consecutive cycles, where L is the selected low count.
- R3: A high phase keeps SCL released, with `bus_busy` at 1 and `start_hold` at 0, for exactly max(H,6)+8 cycles, where H is the selected high count.
- R4: When `start_req` is sampled at 1 in idle with `enable` at 1, `start_hold` is at 1 and SCL is released for exactly max(H,6)+3 cycles. The first low phase follows directly.
- R5: A high count below 6 gives the same phase lengths as a count of 6. A low count below 8 gives the same phase lengths as a count of 8.
- R6: The count inputs and `speed_fast` are captured only on clock edges at which `enable` is 0. Changing them while `enable` is 1 has no effect on the phase lengths.
- R7: `scl_fall_stb` is 1 for exactly one cycle, the first cycle of every low phase. `scl_rise_stb` is 1 for exactly one cycle, the first cycle of every high phase. Neither strobe is 1 at any other time.
- R8: When a high phase ends with `run_req` at 1 and no pending stop, a new low phase begins in the next cycle. Otherwise the block goes idle: `bus_busy` is 0 and SCL is released.
- R9: A `stop_req` pulse during a START hold or a low phase makes the block go idle at the end of the following high phase, even when `run_req` is 1.
- R10: When `enable` is sampled at 0 during any phase, the next cycle is idle with SCL released.
- R11: While reset is asserted and after reset is released, all outputs are 0 until a START is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; count and speed inputs are captured while this is 0 |
| speed_fast | input | 1 | 1 selects the fast count pair, 0 the standard pair |
| std_hi_cnt | input | CNT_W | Standard-speed high count |
| std_lo_cnt | input | CNT_W | Standard-speed low count |
| fast_hi_cnt | input | CNT_W | Fast-speed high count |
| fast_lo_cnt | input | CNT_W | Fast-speed low count |
| start_req | input | 1 | Begin a START hold from idle |
| stop_req | input | 1 | End the transfer after the current high phase |
| run_req | input | 1 | Continue with another clock period after the high phase |
| scl_drive_low | output | 1 | Open-drain pull-down of SCL |
| scl_fall_stb | output | 1 | One-cycle strobe at SCL falling edges |
| scl_rise_stb | output | 1 | One-cycle strobe at SCL rising edges |
| start_hold | output | 1 | High during the START hold interval |
| bus_busy | output | 1 | High whenever the block is not idle |

## Verification
The bench builds the block with 6-bit counts instead of 16-bit ones. This keeps every phase short enough that a complete sweep fits in the cycle budget. The sweep covers every high and low count from 0 to 11 at both speeds. That range reaches the clamp floors and the values on either side of them. On each run the unused pair is loaded with different values, so selecting the wrong pair shows up as a wrong length. Dedicated runs change the counts mid-transfer, raise a stop during a low phase, and drop the enable in the middle of a low phase.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_LOW  = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // fixed cycle overheads added to the programmed counts
  localparam int HIGH_OVH = 8;
  localparam int LOW_OVH  = 1;
  localparam int HOLD_OVH = 3;
endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow #(
  parameter int CNT_W  = 16,
  parameter int HI_MIN = 6,
  parameter int LO_MIN = 8,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             speed_fast,
  input  logic [CNT_W-1:0] std_hi_cnt,
  input  logic [CNT_W-1:0] std_lo_cnt,
  input  logic [CNT_W-1:0] fast_hi_cnt,
  input  logic [CNT_W-1:0] fast_lo_cnt,
  output logic [LEN_W-1:0] hold_reload,
  output logic [LEN_W-1:0] low_reload,
  output logic [LEN_W-1:0] high_reload
);
  import scl_timing_pkg::*;

  // index 0: high count, index 1: low count
  logic [1:0][CNT_W-1:0] sel_d, sel_q, clamped;
  logic                  cap_en;

  assign cap_en   = ~enable;
  assign sel_d[0] = speed_fast ? fast_hi_cnt : std_hi_cnt;
  assign sel_d[1] = speed_fast ? fast_lo_cnt : std_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (cap_en) begin
      sel_q <= sel_d;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_clamp
    localparam int MINV = (i == 0) ? HI_MIN : LO_MIN;
    always_comb begin
      if (sel_q[i] < CNT_W'(MINV)) clamped[i] = CNT_W'(MINV);
      else                         clamped[i] = sel_q[i];
    end
  end

  // reload values are phase length minus one
  always_comb begin
    hold_reload = {1'b0, clamped[0]} + LEN_W'(HOLD_OVH - 1);
    high_reload = {1'b0, clamped[0]} + LEN_W'(HIGH_OVH - 1);
    low_reload  = {1'b0, clamped[1]} + LEN_W'(LOW_OVH - 1);
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             run_req,
  input  logic             expired,
  input  logic [LEN_W-1:0] hold_reload,
  input  logic [LEN_W-1:0] low_reload,
  input  logic [LEN_W-1:0] high_reload,
  output logic             ctr_load,
  output logic [LEN_W-1:0] ctr_val,
  output logic             drive_low,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             in_hold,
  output logic             busy
);
  import scl_timing_pkg::*;

  scl_phase_e ph_q, ph_d;
  logic       stop_q, stop_d;
  logic       fall_q, fall_d, rise_q, rise_d;
  logic       stop_now;

  assign stop_now = stop_q | stop_req;

  always_comb begin
    ph_d     = ph_q;
    ctr_load = 1'b0;
    ctr_val  = low_reload;
    fall_d   = 1'b0;
    rise_d   = 1'b0;
    stop_d   = (ph_q != PH_IDLE) & stop_now;
    if (!enable) begin
      ph_d   = PH_IDLE;
      stop_d = 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_req) begin
          ph_d     = PH_HOLD;
          ctr_load = 1'b1;
          ctr_val  = hold_reload;
        end
        PH_HOLD: if (expired) begin
          ph_d     = PH_LOW;
          ctr_load = 1'b1;
          ctr_val  = low_reload;
          fall_d   = 1'b1;
        end
        PH_LOW: if (expired) begin
          ph_d     = PH_HIGH;
          ctr_load = 1'b1;
          ctr_val  = high_reload;
          rise_d   = 1'b1;
        end
        PH_HIGH: if (expired) begin
          if (run_req && !stop_now) begin
            ph_d     = PH_LOW;
            ctr_load = 1'b1;
            ctr_val  = low_reload;
            fall_d   = 1'b1;
          end else begin
            ph_d   = PH_IDLE;
            stop_d = 1'b0;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      stop_q <= 1'b0;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      stop_q <= stop_d;
      fall_q <= fall_d;
      rise_q <= rise_d;
    end
  end

  assign drive_low = (ph_q == PH_LOW);
  assign in_hold   = (ph_q == PH_HOLD);
  assign busy      = (ph_q != PH_IDLE);
  assign fall_stb  = fall_q;
  assign rise_stb  = rise_q;
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CNT_W  = 16,
  parameter int HI_MIN = 6,
  parameter int LO_MIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             speed_fast,
  input  logic [CNT_W-1:0] std_hi_cnt,
  input  logic [CNT_W-1:0] std_lo_cnt,
  input  logic [CNT_W-1:0] fast_hi_cnt,
  input  logic [CNT_W-1:0] fast_lo_cnt,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             run_req,
  output logic             scl_drive_low,
  output logic             scl_fall_stb,
  output logic             scl_rise_stb,
  output logic             start_hold,
  output logic             bus_busy
);
  localparam int LEN_W = CNT_W + 1;

  logic [LEN_W-1:0] hold_rl, low_rl, high_rl, ctr_val;
  logic             ctr_load, ctr_exp;

  scl_cfg_shadow #(.CNT_W(CNT_W), .HI_MIN(HI_MIN), .LO_MIN(LO_MIN)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .speed_fast  (speed_fast),
    .std_hi_cnt  (std_hi_cnt),
    .std_lo_cnt  (std_lo_cnt),
    .fast_hi_cnt (fast_hi_cnt),
    .fast_lo_cnt (fast_lo_cnt),
    .hold_reload (hold_rl),
    .low_reload  (low_rl),
    .high_reload (high_rl)
  );

  scl_phase_ctr #(.W(LEN_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_val (ctr_val),
    .expired  (ctr_exp)
  );

  scl_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .start_req   (start_req),
    .stop_req    (stop_req),
    .run_req     (run_req),
    .expired     (ctr_exp),
    .hold_reload (hold_rl),
    .low_reload  (low_rl),
    .high_reload (high_rl),
    .ctr_load    (ctr_load),
    .ctr_val     (ctr_val),
    .drive_low   (scl_drive_low),
    .fall_stb    (scl_fall_stb),
    .rise_stb    (scl_rise_stb),
    .in_hold     (start_hold),
    .busy        (bus_busy)
  );
endmodule

// File: rtl/scl_timing_checker.sv
module scl_timing_checker #(
  parameter int CNT_W  = 16,
  parameter int LO_MIN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_drive_low,
  input logic scl_fall_stb,
  input logic scl_rise_stb,
  input logic start_hold,
  input logic bus_busy
);
  localparam int RUN_W = CNT_W + 3;
  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_run <= '0;
    else if (scl_drive_low) low_run <= low_run + RUN_W'(1);
    else                    low_run <= '0;
  end

  assert_fall_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> scl_fall_stb);
  assert_fall_in_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_stb |-> scl_drive_low);
  assert_rise_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_stb |-> (!scl_drive_low && $past(scl_drive_low) && bus_busy));
  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bus_busy && !scl_drive_low));
  assert_low_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drive_low) && $past(enable)) |-> (low_run >= RUN_W'(LO_MIN + 1)));
  assert_hold_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_hold |-> (!scl_drive_low && bus_busy));
endmodule

bind scl_timing_gen scl_timing_checker #(.CNT_W(CNT_W), .LO_MIN(LO_MIN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .scl_drive_low (scl_drive_low),
  .scl_fall_stb  (scl_fall_stb),
  .scl_rise_stb  (scl_rise_stb),
  .start_hold    (start_hold),
  .bus_busy      (bus_busy)
);

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  localparam int CW = 6;

  logic          clk, rst_n, enable, speed_fast, start_req, stop_req, run_req;
  logic [CW-1:0] std_hi_cnt, std_lo_cnt, fast_hi_cnt, fast_lo_cnt;
  logic          scl_drive_low, scl_fall_stb, scl_rise_stb, start_hold, bus_busy;

  int total = 0;
  int fails = 0;

  scl_timing_gen #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .speed_fast(speed_fast),
    .std_hi_cnt(std_hi_cnt), .std_lo_cnt(std_lo_cnt),
    .fast_hi_cnt(fast_hi_cnt), .fast_lo_cnt(fast_lo_cnt),
    .start_req(start_req), .stop_req(stop_req), .run_req(run_req),
    .scl_drive_low(scl_drive_low), .scl_fall_stb(scl_fall_stb),
    .scl_rise_stb(scl_rise_stb), .start_hold(start_hold), .bus_busy(bus_busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input bit fast, input int hi, input int lo);
    speed_fast = fast;
    if (fast) begin
      fast_hi_cnt = CW'(hi);      fast_lo_cnt = CW'(lo);
      std_hi_cnt  = CW'(hi + 20); std_lo_cnt  = CW'(lo + 20);
    end else begin
      std_hi_cnt  = CW'(hi);      std_lo_cnt  = CW'(lo);
      fast_hi_cnt = CW'(hi + 20); fast_lo_cnt = CW'(lo + 20);
    end
  endtask

  // one transfer: hold, low, high, then (unless stopped) low, high, idle
  task automatic run_cfg(input bit fast, input int hi, input int lo,
                         input bit chg, input bit stp);
    int ehi, elo, n, bad;
    ehi = (hi < 6) ? 6 : hi;   // R5 clamp floors
    elo = (lo < 8) ? 8 : lo;
    bad = 0;
    @(negedge clk);
    enable = 1'b0; start_req = 1'b0; stop_req = 1'b0; run_req = 1'b1;
    load_cfg(fast, hi, lo);
    repeat (2) @(negedge clk);
    enable = 1'b1; start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    n = 0;
    while (start_hold && n < 500) begin
      if (scl_drive_low || scl_fall_stb || scl_rise_stb) bad++;
      n++; @(negedge clk);
    end
    chk("R4 start hold length", n, ehi + 3);
    chk("R7 fall strobe at first low", int'(scl_fall_stb), 1);
    n = 0;
    while (scl_drive_low && n < 500) begin
      if ((n > 0 && scl_fall_stb) || scl_rise_stb) bad++;
      if (n == 0 && chg) begin  // R6: ignored while enabled
        speed_fast = ~speed_fast;
        std_hi_cnt = '0; std_lo_cnt = '1; fast_hi_cnt = '1; fast_lo_cnt = '0;
      end
      stop_req = stp && (n == 0);
      n++; @(negedge clk);
    end
    stop_req = 1'b0;
    chk(fast ? "R2 R1 low length fast" : "R2 R1 low length std", n, elo + 1);
    chk("R7 rise strobe at first high", int'(scl_rise_stb), 1);
    n = 0;
    while (bus_busy && !scl_drive_low && n < 500) begin
      if (n > 0 && scl_rise_stb) bad++;
      if (scl_fall_stb) bad++;
      n++; @(negedge clk);
    end
    chk(fast ? "R3 R1 high length fast" : "R3 R1 high length std", n, ehi + 8);
    if (stp) begin
      chk("R9 idle after stop", int'(bus_busy) + int'(scl_drive_low), 0);
    end else begin
      chk("R8 next low follows with run", int'(scl_drive_low), 1);
      n = 0;
      while (scl_drive_low && n < 500) begin
        if (n > 0 && scl_fall_stb) bad++;
        run_req = 1'b0;
        n++; @(negedge clk);
      end
      chk(chg ? "R6 low length after change" : "R2 second low length", n, elo + 1);
      n = 0;
      while (bus_busy && !scl_drive_low && n < 500) begin
        n++; @(negedge clk);
      end
      chk(chg ? "R6 high length after change" : "R3 second high length", n, ehi + 8);
      chk("R8 idle without run", int'(bus_busy) + int'(scl_drive_low), 0);
    end
    chk("R7 no stray strobes", bad, 0);
    enable = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; speed_fast = 1'b0;
    start_req = 1'b0; stop_req = 1'b0; run_req = 1'b0;
    std_hi_cnt = '0; std_lo_cnt = '0; fast_hi_cnt = '0; fast_lo_cnt = '0;
    repeat (3) @(negedge clk);
    chk("R11 outputs in reset", int'(scl_drive_low) + int'(scl_fall_stb) +
        int'(scl_rise_stb) + int'(start_hold) + int'(bus_busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 outputs after reset", int'(scl_drive_low) + int'(scl_fall_stb) +
        int'(scl_rise_stb) + int'(start_hold) + int'(bus_busy), 0);

    for (int s = 0; s < 2; s++)
      for (int h = 0; h < 12; h++)
        for (int l = 0; l < 12; l++)
          run_cfg(s[0], h, l, 1'b0, 1'b0);

    run_cfg(1'b0, 9, 10, 1'b1, 1'b0);
    run_cfg(1'b1, 3, 14, 1'b1, 1'b0);
    run_cfg(1'b0, 7, 9, 1'b0, 1'b1);
    run_cfg(1'b1, 11, 2, 1'b0, 1'b1);

    // R10: disable in mid low phase
    @(negedge clk);
    load_cfg(1'b0, 10, 12); run_req = 1'b1;
    repeat (2) @(negedge clk);
    enable = 1'b1; start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    while (!scl_drive_low) @(negedge clk);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R10 released after disable", int'(scl_drive_low) + int'(bus_busy), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule